// File: doc/BRIEF.md
# ADC Output Formatter with Test Patterns

This block takes a stream of 16-bit two's-complement samples and prepares each one for a converter's output pins. A live sample first gets a signed offset correction. The sum saturates at the 16-bit limits. A control field can replace the live sample with one of seven test patterns: three fixed levels, two alternating words and two pseudo-noise sequences. The chosen word is then recoded as offset binary, two's complement or Gray code, and the whole word can be bit-inverted.

Each sample is marked by a valid strobe. The result comes out of one register stage, with a matching valid flag. The control fields come from a configuration register bank. When all controls are zero, the block passes live data, adds no offset and produces offset binary.

The two pseudo-noise generators are linear feedback shift registers. The short one is 9 bits with feedback from bits 9 and 5. The long one is 23 bits with feedback from bits 23 and 18. Each can be reseeded to all ones through its own control bit.

Top module: `adc_out_formatter`

## Requirements
- R1: Reset, active low, clears `out_valid` and `out_data` to zero. With every control input at zero, a sample `x` leaves as `x ^ 16'h8000` (offset binary).
- R2: `out_valid` goes high in the cycle after `in_valid` was high, and low in the cycle after it was low. `out_data` keeps its value in every cycle that follows a cycle without `in_valid`.
- R3: In test mode 3'b000, the word fed to the coder is the sample plus the sign-extended 8-bit `offset_adj`. A sum above 16'h7FFF is clamped to 16'h7FFF, and a sum below 16'h8000 is clamped to 16'h8000.
- R4: Test modes 3'b001, 3'b010 and 3'b011 give the two's-complement words 16'h0000, 16'h7FFF and 16'h8000. No offset is added to them, and they pass through the same coder as live data.
- R5: A phase bit starts at 0 after reset and flips on every valid sample, whatever the mode. Mode 3'b100 gives 16'h5555 at phase 0 and 16'hAAAA at phase 1. Mode 3'b111 gives 16'h0000 at phase 0 and 16'hFFFF at phase 1.
- R6: Mode 3'b110 gives the 9-bit short generator state `s` as the word `{s[6:0], s[8:0]}`. After each valid sample, `s` becomes `{s[7:0], s[8]^s[4]}`.
- R7: Mode 3'b101 gives the 23-bit long generator state `l` as the word `l[15:0]`. After each valid sample, `l` becomes `{l[21:0], l[22]^l[17]}`.
- R8: Both generators start at all ones after reset. While `pn_short_rst` or `pn_long_rst` is high, the matching generator is loaded with all ones and does not advance.
- R9: `out_format` 2'b00 and 2'b11 give offset binary (word ^ 16'h8000). 2'b01 gives the two's-complement word unchanged. 2'b10 gives Gray code `b ^ (b >> 1)`, where `b` is the offset-binary word.
- R10: When `out_invert` is high, the coded word is bitwise complemented before it is registered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe that marks a new sample |
| in_data | input | 16 | Two's-complement sample |
| test_mode | input | 3 | Selects live data or one of seven patterns |
| pn_long_rst | input | 1 | Reseeds the long pseudo-noise generator |
| pn_short_rst | input | 1 | Reseeds the short pseudo-noise generator |
| offset_adj | input | 8 | Signed offset added to live samples |
| out_format | input | 2 | Selects the output coding |
| out_invert | input | 1 | Complements the output word |
| out_valid | output | 1 | Output word is new this cycle |
| out_data | output | 16 | Formatted output word |

## Verification
The assertions assume that `test_mode`, `offset_adj`, `out_format` and `out_invert` are stable in each cycle that has `in_valid` high. Under that assumption, a value seen one cycle later can be tied to the controls sampled at the strobe. The bench changes these fields only while `in_valid` is low. It pulses the generator reseed bits only in cycles without a sample, so every expected pattern follows from a reseed followed by whole steps. Saturation is exercised at both extremes, with the largest offset of each sign.

// File: rtl/adc_fmt_pkg.sv
// Package: shared encodings for the ADC output formatter.
// Assumes a two's-complement sample path; the enum values below are the
// register field encodings.
package adc_fmt_pkg;

    typedef enum logic [2:0] {
        TM_NORMAL   = 3'b000,
        TM_MIDSCALE = 3'b001,
        TM_POS_FS   = 3'b010,
        TM_NEG_FS   = 3'b011,
        TM_CHECKER  = 3'b100,
        TM_PN_LONG  = 3'b101,
        TM_PN_SHORT = 3'b110,
        TM_TOGGLE   = 3'b111
    } test_mode_e;

    typedef enum logic [1:0] {
        FMT_OFFBIN     = 2'b00,
        FMT_TWOS       = 2'b01,
        FMT_GRAY       = 2'b10,
        FMT_OFFBIN_ALT = 2'b11
    } out_fmt_e;

endpackage

// File: rtl/fmt_offset_sat.sv
// Module: fmt_offset_sat
// Adds a sign-extended offset to a two's-complement sample and clamps the
// result to the sample range. Purely combinational.
module fmt_offset_sat #(
    parameter int DATA_W = 16,
    parameter int OFS_W  = 8
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [OFS_W-1:0]  offset,
    output logic [DATA_W-1:0] result
);
    localparam int SUM_W = DATA_W + 1;
    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MAX_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic [SUM_W-1:0] sum;

    // Wide signed sum, then clamp when the two top bits disagree.
    always_comb begin
        sum = {sample[DATA_W-1], sample}
            + {{(SUM_W-OFS_W){offset[OFS_W-1]}}, offset};
        if (sum[SUM_W-1] != sum[SUM_W-2])
            result = sum[SUM_W-1] ? MAX_NEG : MAX_POS;
        else
            result = sum[DATA_W-1:0];
    end
endmodule

// File: rtl/fmt_lfsr.sv
// Module: fmt_lfsr
// Fibonacci LFSR with two feedback taps (LEN and TAP). It reseeds to all ones
// on reset or while clr is high, and otherwise steps once per adv. The output
// word repeats the state bits cyclically to fill OUT_W.
module fmt_lfsr #(
    parameter int LEN   = 9,
    parameter int TAP   = 5,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [OUT_W-1:0] word
);
    logic [LEN-1:0] state;

    // Reseed has priority over stepping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            state <= '1;
        else if (adv)
            state <= {state[LEN-2:0], state[LEN-1] ^ state[TAP-1]};
    end

    // Fill the output word by repeating the state.
    for (genvar i = 0; i < OUT_W; i++) begin : g_word
        assign word[i] = state[i % LEN];
    end
endmodule

// File: rtl/fmt_pattern_gen.sv
// Module: fmt_pattern_gen
// Produces the test-pattern word for the selected mode. It holds the
// alternation phase and the two pseudo-noise generators, all stepped once
// per valid sample whatever the mode.
module fmt_pattern_gen
    import adc_fmt_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SHORT_LEN = 9,
    parameter int SHORT_TAP = 5,
    parameter int LONG_LEN  = 23,
    parameter int LONG_TAP  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  test_mode_e        mode,
    input  logic              clr_long,
    input  logic              clr_short,
    output logic [DATA_W-1:0] pattern
);
    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MAX_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] CHK_A   = {(DATA_W/2){2'b01}};

    logic              phase;
    logic [DATA_W-1:0] short_word;
    logic [DATA_W-1:0] long_word;

    // The alternation phase flips on every valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= 1'b0;
        else if (adv)
            phase <= ~phase;
    end

    fmt_lfsr #(.LEN(SHORT_LEN), .TAP(SHORT_TAP), .OUT_W(DATA_W)) u_pn_short (
        .clk(clk), .rst_n(rst_n), .clr(clr_short), .adv(adv), .word(short_word)
    );

    fmt_lfsr #(.LEN(LONG_LEN), .TAP(LONG_TAP), .OUT_W(DATA_W)) u_pn_long (
        .clk(clk), .rst_n(rst_n), .clr(clr_long), .adv(adv), .word(long_word)
    );

    // Pick the pattern word for the selected mode.
    always_comb begin
        unique case (mode)
            TM_MIDSCALE: pattern = '0;
            TM_POS_FS:   pattern = MAX_POS;
            TM_NEG_FS:   pattern = MAX_NEG;
            TM_CHECKER:  pattern = phase ? ~CHK_A : CHK_A;
            TM_PN_LONG:  pattern = long_word;
            TM_PN_SHORT: pattern = short_word;
            TM_TOGGLE:   pattern = phase ? '1 : '0;
            default:     pattern = '0;
        endcase
    end
endmodule

// File: rtl/fmt_coder.sv
// Module: fmt_coder
// Recodes a two's-complement word as offset binary, two's complement or Gray
// code, then applies the optional inversion. Purely combinational.
module fmt_coder
    import adc_fmt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] word,
    input  out_fmt_e          fmt,
    input  logic              invert,
    output logic [DATA_W-1:0] coded
);
    localparam logic [DATA_W-1:0] SIGN_BIT = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] offbin;
    logic [DATA_W-1:0] pre_inv;

    // Select the coding, then invert if asked.
    always_comb begin
        offbin = word ^ SIGN_BIT;
        unique case (fmt)
            FMT_TWOS: pre_inv = word;
            FMT_GRAY: pre_inv = offbin ^ (offbin >> 1);
            default:  pre_inv = offbin;
        endcase
        coded = invert ? ~pre_inv : pre_inv;
    end
endmodule

// File: rtl/adc_out_formatter.sv
// Module: adc_out_formatter (top)
// Chooses between the offset-corrected live sample and a test pattern,
// recodes the word and registers it with a valid flag. Assumes the control
// fields are steady while in_valid is high.
module adc_out_formatter
    import adc_fmt_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int OFS_W     = 8,
    parameter int SHORT_LEN = 9,
    parameter int SHORT_TAP = 5,
    parameter int LONG_LEN  = 23,
    parameter int LONG_TAP  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [2:0]        test_mode,
    input  logic              pn_long_rst,
    input  logic              pn_short_rst,
    input  logic [OFS_W-1:0]  offset_adj,
    input  logic [1:0]        out_format,
    input  logic              out_invert,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    test_mode_e        mode;
    logic [DATA_W-1:0] corrected;
    logic [DATA_W-1:0] pattern;
    logic [DATA_W-1:0] source;
    logic [DATA_W-1:0] coded;

    assign mode = test_mode_e'(test_mode);

    fmt_offset_sat #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_offset (
        .sample(in_data), .offset(offset_adj), .result(corrected)
    );

    fmt_pattern_gen #(
        .DATA_W(DATA_W), .SHORT_LEN(SHORT_LEN), .SHORT_TAP(SHORT_TAP),
        .LONG_LEN(LONG_LEN), .LONG_TAP(LONG_TAP)
    ) u_pattern (
        .clk(clk), .rst_n(rst_n), .adv(in_valid), .mode(mode),
        .clr_long(pn_long_rst), .clr_short(pn_short_rst), .pattern(pattern)
    );

    // A test pattern, when one is selected, replaces the live sample.
    assign source = (mode == TM_NORMAL) ? corrected : pattern;

    fmt_coder #(.DATA_W(DATA_W)) u_coder (
        .word(source), .fmt(out_fmt_e'(out_format)), .invert(out_invert),
        .coded(coded)
    );

    // Output register: capture on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= coded;
        end
    end
endmodule

// Checker: timing and value properties of the formatter at its ports.
module adc_out_formatter_chk #(
    parameter int DATA_W = 16,
    parameter int OFS_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [2:0]        test_mode,
    input logic [OFS_W-1:0]  offset_adj,
    input logic [1:0]        out_format,
    input logic              out_invert,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MAX_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && out_valid == 1'b0 && $past(rst_n)) |=> $stable(out_data));

    assert_clamp_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && test_mode == 3'b000 && out_format == 2'b01 && !out_invert
         && in_data == MAX_POS && !offset_adj[OFS_W-1]) |=> out_data == MAX_POS);

    assert_clamp_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && test_mode == 3'b000 && out_format == 2'b01 && !out_invert
         && in_data == MAX_NEG && offset_adj[OFS_W-1]) |=> out_data == MAX_NEG);

    assert_pos_fs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && test_mode == 3'b010 && out_format == 2'b01 && !out_invert)
        |=> out_data == MAX_POS);

    assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && test_mode == 3'b111 && out_format == 2'b01)
        |=> ($countones(out_data) == 0 || $countones(out_data) == DATA_W));

    assert_invert_mid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && test_mode == 3'b001 && out_format == 2'b01 && out_invert)
        |=> out_data == '1);
endmodule

bind adc_out_formatter adc_out_formatter_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .test_mode(test_mode), .offset_adj(offset_adj), .out_format(out_format),
    .out_invert(out_invert), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_adc_out_formatter.sv
// Scoreboard bench: the driver computes each expected word from the
// requirements and queues it; the monitor compares on the falling edge.
module test_adc_out_formatter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic [2:0]  test_mode = '0;
    logic        pn_long_rst = 1'b0;
    logic        pn_short_rst = 1'b0;
    logic [7:0]  offset_adj = '0;
    logic [1:0]  out_format = '0;
    logic        out_invert = 1'b0;
    logic        out_valid;
    logic [15:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] last_exp = '0;

    // Reference state, kept from the requirements.
    logic        m_phase = 1'b0;
    logic [8:0]  m_short = '1;
    logic [22:0] m_long  = '1;

    always #10 clk = ~clk;

    adc_out_formatter i_adc_out_formatter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .test_mode(test_mode), .pn_long_rst(pn_long_rst),
        .pn_short_rst(pn_short_rst), .offset_adj(offset_adj),
        .out_format(out_format), .out_invert(out_invert),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sat_add(input logic [15:0] x, input logic [7:0] o);
        int s;
        s = $signed(x) + $signed(o);
        if (s > 32767) return 16'h7FFF;
        if (s < -32768) return 16'h8000;
        return s[15:0];
    endfunction

    function automatic logic [15:0] encode(input logic [15:0] w, input logic [1:0] f, input logic inv);
        logic [15:0] b, r;
        b = w ^ 16'h8000;
        case (f)
            2'b01:   r = w;
            2'b10:   r = b ^ (b >> 1);
            default: r = b;
        endcase
        return inv ? ~r : r;
    endfunction

    // Driver: present one sample, queue its expected word, step the model.
    task automatic send(input logic [15:0] d, input string req);
        logic [15:0] src;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        case (test_mode)
            3'b000: src = sat_add(d, offset_adj);
            3'b001: src = 16'h0000;
            3'b010: src = 16'h7FFF;
            3'b011: src = 16'h8000;
            3'b100: src = m_phase ? 16'hAAAA : 16'h5555;
            3'b101: src = m_long[15:0];
            3'b110: src = {m_short[6:0], m_short};
            default: src = m_phase ? 16'hFFFF : 16'h0000;
        endcase
        exp_q.push_back(encode(src, out_format, out_invert));
        tag_q.push_back(req);
        m_phase = ~m_phase;
        m_short = {m_short[7:0], m_short[8] ^ m_short[4]};
        m_long  = {m_long[21:0], m_long[22] ^ m_long[17]};
    endtask

    // Change controls only in an idle cycle.
    task automatic setup(input logic [2:0] m, input logic [7:0] o, input logic [1:0] f, input logic inv);
        @(negedge clk);
        in_valid = 1'b0;
        test_mode = m; offset_adj = o; out_format = f; out_invert = inv;
    endtask

    task automatic pn_reseed(input logic lng, input logic sht);
        @(negedge clk);
        in_valid = 1'b0;
        pn_long_rst = lng; pn_short_rst = sht;
        @(negedge clk);
        pn_long_rst = 1'b0; pn_short_rst = 1'b0;
        if (lng) m_long = '1;
        if (sht) m_short = '1;
    endtask

    // Monitor: pop and compare each valid word; check hold on idle cycles.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected valid", out_data, 16'hxxxx);
                end else begin
                    last_exp = exp_q.pop_front();
                    check(tag_q.pop_front(), out_data, last_exp);
                end
            end else begin
                check("R2 hold", out_data, last_exp);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset data", out_data, 16'h0000);
        check("R1 reset valid", {15'b0, out_valid}, 16'h0000);
        rst_n = 1'b1;
        send(16'h1234, "R1 default offset binary");
        send(16'hFFFF, "R1 default offset binary");
        setup(3'b000, 8'd5, 2'b01, 1'b0);
        send(16'h0010, "R3 positive offset");
        setup(3'b000, 8'hFF, 2'b01, 1'b0);
        send(16'h0000, "R3 negative offset");
        setup(3'b000, 8'h7F, 2'b01, 1'b0);
        send(16'h7FFF, "R3 clamp high");
        send(16'h7F90, "R3 clamp high");
        setup(3'b000, 8'h80, 2'b01, 1'b0);
        send(16'h8000, "R3 clamp low");
        send(16'h8050, "R3 clamp low");
        send(16'h1000, "R3 negative offset");
        setup(3'b000, 8'h00, 2'b10, 1'b0);
        send(16'h0000, "R9 gray");
        send(16'h4321, "R9 gray");
        send(16'hC001, "R9 gray");
        setup(3'b000, 8'h00, 2'b11, 1'b0);
        send(16'h2222, "R9 format 11");
        setup(3'b000, 8'h03, 2'b00, 1'b1);
        send(16'h0F0F, "R10 invert");
        for (int m = 1; m <= 3; m++) begin
            for (int f = 0; f < 4; f++) begin
                setup(m[2:0], 8'h40, f[1:0], f[0]);
                send(16'h1357, "R4 fixed level");
            end
        end
        setup(3'b100, 8'h00, 2'b01, 1'b0);
        repeat (3) send(16'h0000, "R5 checkerboard");
        setup(3'b111, 8'h00, 2'b01, 1'b0);
        repeat (3) send(16'h0000, "R5 toggle");
        setup(3'b111, 8'h00, 2'b10, 1'b1);
        send(16'h0000, "R5 toggle coded");
        pn_reseed(1'b1, 1'b1);
        setup(3'b110, 8'h00, 2'b01, 1'b0);
        send(16'h0000, "R8 short seed");
        repeat (20) send(16'h0000, "R6 short pn");
        setup(3'b101, 8'h00, 2'b01, 1'b0);
        repeat (40) send(16'h0000, "R7 long pn");
        pn_reseed(1'b0, 1'b1);
        setup(3'b110, 8'h00, 2'b01, 1'b0);
        send(16'h0000, "R8 short reseed");
        setup(3'b101, 8'h00, 2'b01, 1'b0);
        send(16'h0000, "R8 long not reseeded");
        pn_reseed(1'b1, 1'b0);
        send(16'h0000, "R8 long reseed");
        setup(3'b101, 8'h00, 2'b00, 1'b1);
        repeat (5) send(16'h0000, "R7 long pn coded");
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 all outputs seen", 16'(exp_q.size()), 16'h0000);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule